// File: doc/BRIEF.md
# Accumulator ALU with Flag Byte

This block is the combinational arithmetic and logic stage of an 8-bit accumulator machine. Each cycle the surrounding datapath presents an operation code, the accumulator, a second operand and the present flag byte. The block returns the new accumulator value and a new flag byte. The opcode decides, flag by flag, whether each flag is recomputed, forced, inverted or carried through unchanged.

The block has no state and no clock. One bit of the flag byte does two jobs. Bitwise operations load it with the parity of the result. Arithmetic operations load it with signed overflow.

The flag byte layout is fixed because neighbouring logic decodes it: sign is bit 7, zero is bit 6, half-carry is bit 4, parity/overflow is bit 2, subtract is bit 1 and carry is bit 0. Bits 5 and 3 are spare.

Top module: `alu8_core`

## Requirements
- R1: Opcodes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 negate, 6 AND, 7 OR, 8 XOR, 9 increment, 10 decrement, 11 complement, 12 set carry and 13 invert carry. For every opcode that computes a value, sign (bit 7) equals bit 7 of that value and zero (bit 6) is 1 exactly when the value is 0. Spare flag bits 5 and 3 always pass through unchanged.
- R2: Add (0) and add-with-carry (1) set carry (bit 0) on a carry out of bit 7 and half-carry (bit 4) on a carry out of bit 3. Add-with-carry includes the incoming carry flag in both sums.
- R3: Subtract (2) and subtract-with-borrow (3) set carry on a borrow out of bit 7 and half-carry on a borrow out of bit 3. Subtract-with-borrow also subtracts the incoming carry flag.
- R4: For opcodes 0 to 5, 9 and 10, bit 2 is 1 exactly when the signed two's-complement result overflows.
- R5: Bit 1 is set by opcodes 2, 3, 4, 5 and 10, and cleared by opcodes 0, 1 and 9.
- R6: Compare (4) returns the accumulator unchanged as its result. Its flags are those of accumulator minus operand.
- R7: Negate (5) returns 0 minus the accumulator. Bit 2 is set only for an input of 0x80, and carry is set whenever the input is nonzero.
- R8: AND, OR and XOR set bit 2 when the result has an even number of ones, and clear carry and bit 1. Half-carry is 1 for AND and 0 for OR and XOR.
- R9: Increment (9) and decrement (10) add or subtract one and keep the incoming carry flag.
- R10: Complement (11) inverts every accumulator bit and sets half-carry and bit 1. All other flags are kept.
- R11: Set carry (12) forces carry to 1 and clears half-carry and bit 1. Invert carry (13) flips carry, clears bit 1 and keeps half-carry. Both return the accumulator and keep bits 7, 6 and 2.
- R12: Codes 14 and 15 return the accumulator unchanged and the flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opd_i | input | 8 | Second operand |
| flags_i | input | 8 | Current flag byte |
| result_o | output | 8 | New accumulator value |
| flags_o | output | 8 | New flag byte |

## Verification
The embedded checks assume that all inputs change together and have settled when the result is read. They also assume that opcode values are fully defined, including the two reserved codes.

The stimulus meets these assumptions by changing every input once per clock, just after the rising edge, and reading the outputs half a period later. The directed vectors target the nibble and byte carry boundaries, the 0x7F/0x80 overflow edges, zero results and spare-bit passthrough. A long pseudo-random run then covers all sixteen opcodes, with every flag byte value possible.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_CMP  = 4'd4,
    OP_NEG  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_CPL  = 4'd11,
    OP_SCF  = 4'd12,
    OP_CCF  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

  localparam int FL_C  = 0;
  localparam int FL_N  = 1;
  localparam int FL_PV = 2;
  localparam int FL_H  = 4;
  localparam int FL_Z  = 6;
  localparam int FL_S  = 7;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W  = 8,
  parameter int HB = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         carry_o,
  output logic         half_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  logic [HB:0] lo_sum;
  logic [W:0]  full_sum;

  always_comb begin
    if (sub_i) begin
      lo_sum   = {1'b0, a_i[HB-1:0]} - {1'b0, b_i[HB-1:0]} - {{HB{1'b0}}, cin_i};
      full_sum = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
    end else begin
      lo_sum   = {1'b0, a_i[HB-1:0]} + {1'b0, b_i[HB-1:0]} + {{HB{1'b0}}, cin_i};
      full_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    end
  end

  assign res_o   = full_sum[W-1:0];
  assign carry_o = full_sum[W];
  assign half_o  = lo_sum[HB];

  always_comb begin
    if (sub_i) ovf_o = (a_i[MSB] != b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
    else       ovf_o = (a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] res_o,
  output logic         par_even_o
);
  always_comb begin
    case (sel_i)
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i & b_i;
    endcase
  end

  assign par_even_o = ~(^res_o);
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W  = 8,
  parameter int HB = 4
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opd_i,
  input  logic [7:0]   flags_i,
  output logic [W-1:0] result_o,
  output logic [7:0]   flags_o
);
  localparam int MSB = W - 1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // operand steering for the shared adder
  logic [W-1:0] as_a, as_b, as_res;
  logic         as_cin, as_sub, as_c, as_h, as_v;
  logic_sel_e   lg_sel;
  logic [W-1:0] lg_res;
  logic         lg_par;

  always_comb begin
    as_a   = acc_i;
    as_b   = opd_i;
    as_cin = 1'b0;
    as_sub = 1'b0;
    case (op)
      OP_ADC: as_cin = flags_i[FL_C];
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBC: begin
        as_sub = 1'b1;
        as_cin = flags_i[FL_C];
      end
      OP_NEG: begin
        as_a   = '0;
        as_b   = acc_i;
        as_sub = 1'b1;
      end
      OP_INC: as_b = ONE;
      OP_DEC: begin
        as_b   = ONE;
        as_sub = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (op)
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_AND;
    endcase
  end

  alu8_addsub #(.W(W), .HB(HB)) addsub_i (
    .a_i(as_a), .b_i(as_b), .cin_i(as_cin), .sub_i(as_sub),
    .res_o(as_res), .carry_o(as_c), .half_o(as_h), .ovf_o(as_v)
  );

  alu8_logic #(.W(W)) logic_i (
    .a_i(acc_i), .b_i(opd_i), .sel_i(lg_sel),
    .res_o(lg_res), .par_even_o(lg_par)
  );

  // result and flag merge
  always_comb begin
    result_o = acc_i;
    flags_o  = flags_i;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_NEG, OP_INC, OP_DEC: begin
        if (op != OP_CMP) result_o = as_res;
        flags_o[FL_S]  = as_res[MSB];
        flags_o[FL_Z]  = (as_res == '0);
        flags_o[FL_H]  = as_h;
        flags_o[FL_PV] = as_v;
        flags_o[FL_N]  = as_sub;
        if (op != OP_INC && op != OP_DEC) flags_o[FL_C] = as_c;
      end
      OP_AND, OP_OR, OP_XOR: begin
        result_o       = lg_res;
        flags_o[FL_S]  = lg_res[MSB];
        flags_o[FL_Z]  = (lg_res == '0);
        flags_o[FL_H]  = (op == OP_AND);
        flags_o[FL_PV] = lg_par;
        flags_o[FL_N]  = 1'b0;
        flags_o[FL_C]  = 1'b0;
      end
      OP_CPL: begin
        result_o      = ~acc_i;
        flags_o[FL_H] = 1'b1;
        flags_o[FL_N] = 1'b1;
      end
      OP_SCF: begin
        flags_o[FL_C] = 1'b1;
        flags_o[FL_H] = 1'b0;
        flags_o[FL_N] = 1'b0;
      end
      OP_CCF: begin
        flags_o[FL_C] = ~flags_i[FL_C];
        flags_o[FL_N] = 1'b0;
      end
      default: ;
    endcase
  end

  // embedded checks
  always_comb begin
    // R1
    spare_bits_pass_chk: assert (flags_o[5] == flags_i[5] && flags_o[3] == flags_i[3]);
    if (op == OP_CMP) begin
      // R6
      cmp_no_writeback_chk: assert (result_o == acc_i && flags_o[FL_N]);
    end
    if (op == OP_NEG) begin
      // R7
      neg_flags_chk: assert (flags_o[FL_PV] == (acc_i == {1'b1, {(W-1){1'b0}}}) &&
                             flags_o[FL_C] == (acc_i != '0));
    end
    if (op == OP_AND || op == OP_OR || op == OP_XOR) begin
      // R8
      logic_clears_cn_chk: assert (!flags_o[FL_C] && !flags_o[FL_N]);
    end
    if (op == OP_INC || op == OP_DEC) begin
      // R9
      step_keeps_carry_chk: assert (flags_o[FL_C] == flags_i[FL_C]);
    end
    if (op == OP_CPL) begin
      // R10
      cpl_inverts_chk: assert ((result_o ^ acc_i) == '1 && flags_o[FL_H] && flags_o[FL_N]);
    end
    if (op == OP_RSV0 || op == OP_RSV1) begin
      // R12
      reserved_passthru_chk: assert (result_o == acc_i && flags_o == flags_i);
    end
  end
endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  logic       clk;
  logic       rst_n;
  logic [3:0] op;
  logic [7:0] acc, opd, fin;
  logic [7:0] res, fout;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [3:0] op;
    logic [7:0] a, b, f, er, ef;
    string      tag;
  } item_t;
  item_t q[$];

  alu8_core dut_i (
    .op_i(op), .acc_i(acc), .opd_i(opd), .flags_i(fin),
    .result_o(res), .flags_o(fout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int sx(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  function automatic void arith(input int a, input int b, input int ci, input bit sub,
                                output logic [7:0] r, output bit c, output bit h, output bit v);
    int s, sv;
    if (!sub) begin
      s  = a + b + ci;
      c  = s > 255;
      h  = (a % 16) + (b % 16) + ci > 15;
      sv = sx(a) + sx(b) + ci;
    end else begin
      s  = a - b - ci;
      c  = s < 0;
      h  = (a % 16) - (b % 16) - ci < 0;
      sv = sx(a) - sx(b) - ci;
    end
    v = (sv > 127) || (sv < -128);
    r = 8'((s + 512) % 256);
  endfunction

  function automatic void model(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                                input logic [7:0] f, output logic [7:0] r, output logic [7:0] fo);
    logic [7:0] ar;
    bit c, h, v, sub;
    int ones;
    r  = a;
    fo = f;
    if (o <= 5 || o == 9 || o == 10) begin
      sub = (o == 2 || o == 3 || o == 4 || o == 5 || o == 10);
      case (o)
        0: arith(int'(a), int'(b), 0, 0, ar, c, h, v);
        1: arith(int'(a), int'(b), int'(f[0]), 0, ar, c, h, v);
        2, 4: arith(int'(a), int'(b), 0, 1, ar, c, h, v);
        3: arith(int'(a), int'(b), int'(f[0]), 1, ar, c, h, v);
        5: arith(0, int'(a), 0, 1, ar, c, h, v);
        9: arith(int'(a), 1, 0, 0, ar, c, h, v);
        default: arith(int'(a), 1, 0, 1, ar, c, h, v);
      endcase
      if (o != 4) r = ar;
      fo[7] = ar[7];
      fo[6] = (ar == 8'd0);
      fo[4] = h;
      fo[2] = v;
      fo[1] = sub;
      if (o != 9 && o != 10) fo[0] = c;
    end else if (o >= 6 && o <= 8) begin
      r = (o == 6) ? (a & b) : (o == 7) ? (a | b) : (a ^ b);
      ones = 0;
      for (int i = 0; i < 8; i++) ones += int'(r[i]);
      fo[7] = r[7];
      fo[6] = (r == 8'd0);
      fo[4] = (o == 6);
      fo[2] = (ones % 2 == 0);
      fo[1] = 1'b0;
      fo[0] = 1'b0;
    end else if (o == 11) begin
      r = ~a;
      fo[4] = 1'b1;
      fo[1] = 1'b1;
    end else if (o == 12) begin
      fo[0] = 1'b1;
      fo[4] = 1'b0;
      fo[1] = 1'b0;
    end else if (o == 13) begin
      fo[0] = ~f[0];
      fo[1] = 1'b0;
    end
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      0, 1: return "R2";
      2, 3: return "R3";
      4: return "R6";
      5: return "R7";
      6, 7, 8: return "R8";
      9, 10: return "R9";
      11: return "R10";
      12, 13: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic drive(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] f, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    op = o; acc = a; opd = b; fin = f;
    it.op = o; it.a = a; it.b = b; it.f = f; it.tag = tag;
    model(o, a, b, f, it.er, it.ef);
    q.push_back(it);
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        n_cmp++;
        if (res !== it.er || fout !== it.ef) begin
          n_bad++;
          $display("FAIL %s op=%0d a=%02h b=%02h f=%02h: got res=%02h flags=%02h, expected res=%02h flags=%02h",
                   it.tag, it.op, it.a, it.b, it.f, res, fout, it.er, it.ef);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    op = 4'd0; acc = 8'd0; opd = 8'd0; fin = 8'd0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 idle/reset state: zero add yields zero flag only
    drive(4'd0, 8'h00, 8'h00, 8'h00, "R1 reset");
    // R2 half and full carry, carry-in folding
    drive(4'd0, 8'h0F, 8'h01, 8'h00, "R2 half carry");
    drive(4'd0, 8'hFF, 8'h01, 8'h28, "R2 wrap to zero, R1 spare bits");
    drive(4'd1, 8'h0F, 8'h00, 8'h01, "R2 carry-in into nibble");
    drive(4'd1, 8'hFE, 8'h01, 8'h01, "R2 carry-in into byte");
    // R4 overflow edges
    drive(4'd0, 8'h7F, 8'h01, 8'h00, "R4 add overflow");
    drive(4'd3, 8'h80, 8'h00, 8'h01, "R4 borrow-in overflow");
    // R3 borrows
    drive(4'd2, 8'h10, 8'h01, 8'h00, "R3 half borrow");
    drive(4'd2, 8'h00, 8'h01, 8'h00, "R3 full borrow");
    drive(4'd3, 8'h00, 8'h00, 8'h01, "R3 borrow-in");
    // R5 subtract flag set then cleared
    drive(4'd2, 8'h05, 8'h03, 8'h00, "R5 sub sets N");
    drive(4'd0, 8'h05, 8'h03, 8'h02, "R5 add clears N");
    // R6 compare
    drive(4'd4, 8'h05, 8'h05, 8'h00, "R6 equal compare");
    drive(4'd4, 8'h05, 8'h06, 8'h00, "R6 less compare");
    // R7 negate
    drive(4'd5, 8'h00, 8'h00, 8'h01, "R7 negate zero");
    drive(4'd5, 8'h80, 8'h00, 8'h00, "R7 negate 0x80");
    drive(4'd5, 8'h01, 8'h00, 8'h00, "R7 negate one");
    // R8 logic
    drive(4'd6, 8'hF0, 8'h0F, 8'h13, "R8 and zero even");
    drive(4'd7, 8'h01, 8'h00, 8'h13, "R8 or odd parity");
    drive(4'd8, 8'hFF, 8'h0F, 8'h01, "R8 xor");
    // R9 step keeps carry
    drive(4'd9, 8'hFF, 8'h00, 8'h00, "R9 inc wrap keep C=0");
    drive(4'd10, 8'h80, 8'h00, 8'h01, "R9 dec overflow keep C=1");
    drive(4'd10, 8'h00, 8'h00, 8'h00, "R9 dec zero");
    // R10 complement
    drive(4'd11, 8'h5A, 8'h00, 8'hC5, "R10 complement");
    // R11 carry ops
    drive(4'd12, 8'h33, 8'h00, 8'hD6, "R11 set carry");
    drive(4'd13, 8'h33, 8'h00, 8'hD7, "R11 invert carry 1->0");
    drive(4'd13, 8'h33, 8'h00, 8'h12, "R11 invert carry 0->1");
    // R12 reserved codes
    drive(4'd14, 8'hA5, 8'h3C, 8'hFF, "R12 code 14");
    drive(4'd15, 8'h5A, 8'hC3, 8'h00, "R12 code 15");
    // pseudo-random sweep over every opcode
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] ro;
      ro = 4'($urandom_range(0, 15));
      drive(ro, 8'($urandom), 8'($urandom), 8'($urandom), tag_of(ro));
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule